// File: doc/BRIEF.md
# SPI Master Engine with Bypassable Word Queues

This block is a serial-peripheral-interface master that moves 16-bit words between software and one slave device. Software writes transmit words into a transmit queue and reads received words from a receive queue through a plain strobe-based write/read interface. The engine takes words from the transmit queue, drives a single active-low chip select, produces a serial clock that idles low and shifts each word out most-significant bit first. At the same time it shifts in the slave's serial data and pushes each completed word into the receive queue.

A small control register sets the behaviour. Each queue can be cut down to a single double-buffered holding register. Each queue has a one-shot flush strobe. A run/stop bit gates the start of new frames. A two-bit field delays the capture of the serial input by up to two system clocks after the rising serial clock edge, so a slow slave with a long clock-to-output path can still be read at a high serial clock rate.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control readback is 7'h01 (stopped, both queues in queue mode, delay 0). Both queues are empty, the overflow flag is 0, cs_n is 1 and sck is 0.
- R2: A control write sets stop = bit 0, tx single-buffer = bit 1, rx single-buffer = bit 2, tx flush = bit 3, rx flush = bit 4 and sample delay = bits 6:5. The readback holds the same layout, and bits 3 and 4 always read 0.
- R3: In queue mode the transmit queue holds 4 words and raises tx_full after the fourth. A write while full is dropped, and the queued words go out in write order.
- R4: A frame holds cs_n low and makes 16 sck pulses with a period of 2*HALF_DIV system clocks. sout changes with each rising sck edge and is stable at the falling edge, most-significant bit first. sck is low whenever cs_n is high.
- R5: The serial input is captured d system clocks after the clock edge that raises sck. The delay field selects d: 00→0, 01→1, 10→2, and the reserved code 11→2.
- R6: In queue mode the receive queue holds 4 words and raises rx_full after the fourth. rx_rdata shows the oldest word, rx_re removes it, and rx_re on an empty queue is ignored.
- R7: With tx single-buffer set, the transmit side holds one word: tx_full rises after one write, and a second write before it is sent is dropped.
- R8: With rx single-buffer set, the receive side holds one word: it is full after one received frame.
- R9: Writing 1 to the tx flush bit empties the transmit queue. A control write with that bit at 0 leaves the queued words in place.
- R10: Writing 1 to the rx flush bit empties the receive queue and clears the overflow flag.
- R11: A word that completes while the receive side is full is dropped, and rx_ovf is set and stays set until an rx flush.
- R12: Setting the stop bit lets a frame already in progress finish, and no new frame starts while the bit is 1. Clearing it lets queued words go out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control write data |
| cfg_rdata | output | 7 | Control readback |
| tx_we | input | 1 | Transmit word write strobe |
| tx_wdata | input | 16 | Transmit word |
| tx_full | output | 1 | Transmit side cannot accept a word |
| tx_empty | output | 1 | Transmit side holds no word |
| rx_re | input | 1 | Receive word read strobe (removes head) |
| rx_rdata | output | 16 | Oldest received word |
| rx_full | output | 1 | Receive side cannot accept a word |
| rx_empty | output | 1 | Receive side holds no word |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| sck | output | 1 | Serial clock, idle low |
| sout | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| sin | input | 1 | Serial data in |

## Verification
The bench models a slave whose output changes one or two system clocks after each rising sck edge. For every delay code it predicts whether the master captures the new bit or the previous one. A design that ignored the delay field, mapped the reserved code elsewhere, or sampled one clock off would return a word shifted by one bit. Other cases it targets are writes into a full transmit queue and frames arriving at a full receive side; a design that overwrote entries would send a fifth word or lose the oldest received word. It also checks a read of an empty receive queue, which a wrong design would let corrupt the pointers. It checks that a flush strobe and an ordinary control write differ, and that the stop bit lets the running frame finish but holds back the next one; a design that aborted or kept going would show a wrong frame count.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam int CFG_W      = 7;
    localparam int CB_STOP    = 0;
    localparam int CB_TX_SGL  = 1;
    localparam int CB_RX_SGL  = 2;
    localparam int CB_TX_CLR  = 3;
    localparam int CB_RX_CLR  = 4;
    localparam int CB_DLY_LO  = 5;

    typedef struct packed {
        logic       stop;
        logic       tx_sgl;
        logic       rx_sgl;
        logic [1:0] dly_code;
        logic       ovf;
    } ctrl_t;

    // Reserved code 11 behaves as a two-cycle delay.
    function automatic logic [1:0] decode_delay(input logic [1:0] code);
        return (code == 2'b11) ? 2'd2 : code;
    endfunction
endpackage

// File: rtl/spi_word_buf.sv
module spi_word_buf #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         single,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
    } buf_t;

    buf_t s_d, s_q;
    logic [CW-1:0] limit;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign limit   = single ? CW'(1) : CW'(DEPTH);
    assign full    = (s_q.cnt >= limit);
    assign empty   = (s_q.cnt == '0);
    assign head    = s_q.mem[s_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.rp  = '0;
            s_d.wp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = push_data;
                s_d.wp          = step(s_q.wp);
            end
            if (do_pop) s_d.rp = step(s_q.rp);
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3 / R6: a write into a full buffer leaves the fill level alone
    a_r3_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (s_q.cnt == $past(s_q.cnt)));
    // R9 / R10: a flush strobe leaves the buffer empty
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W        = 16,
    parameter int HALF_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop,
    input  logic [1:0]   dly,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_word,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    input  logic         sin,
    output logic         sck,
    output logic         sout,
    output logic         cs_n
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int EW = $clog2(2 * W + 1);
    localparam int BW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic          sout;
        logic          csn;
        logic [DW-1:0] div;
        logic [EW-1:0] edges;
        logic [W-1:0]  tsh;
        logic [W-1:0]  rsh;
        logic          pend;
        logic [1:0]    left;
        logic [BW-1:0] nbits;
    } eng_t;

    eng_t s_d, s_q;
    logic capture;

    always_comb begin
        s_d     = s_q;
        tx_pop  = 1'b0;
        capture = 1'b0;
        if (!s_q.busy) begin
            if (!stop && tx_avail) begin
                tx_pop      = 1'b1;
                s_d.busy    = 1'b1;
                s_d.csn     = 1'b0;
                s_d.div     = '0;
                s_d.edges   = '0;
                s_d.tsh     = tx_word;
                s_d.rsh     = '0;
                s_d.nbits   = '0;
                s_d.pend    = 1'b0;
            end
        end else begin
            if (s_q.pend) begin
                if (s_q.left == 2'd1) begin
                    capture  = 1'b1;
                    s_d.pend = 1'b0;
                end else begin
                    s_d.left = s_q.left - 1'b1;
                end
            end
            if (s_q.div == DW'(HALF_DIV - 1)) begin
                s_d.div = '0;
                if (s_q.edges == EW'(2 * W)) begin
                    s_d.busy = 1'b0;
                    s_d.csn  = 1'b1;
                    s_d.sout = 1'b0;
                end else begin
                    s_d.sck   = !s_q.sck;
                    s_d.edges = s_q.edges + 1'b1;
                    if (!s_q.sck) begin
                        s_d.sout = s_q.tsh[W-1];
                        s_d.tsh  = {s_q.tsh[W-2:0], 1'b0};
                        if (dly == 2'd0) begin
                            capture = 1'b1;
                        end else begin
                            s_d.pend = 1'b1;
                            s_d.left = dly;
                        end
                    end
                end
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end
        if (capture) begin
            s_d.rsh   = {s_q.rsh[W-2:0], sin};
            s_d.nbits = s_q.nbits + 1'b1;
        end
    end

    assign rx_push = capture && (s_q.nbits == BW'(W - 1));
    assign rx_word = {s_q.rsh[W-2:0], sin};
    assign sck     = s_q.sck;
    assign sout    = s_q.sout;
    assign cs_n    = s_q.csn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.csn <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: the serial clock rests low while the slave is deselected
    a_r4_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.csn |-> !s_q.sck);
    // R12: no frame begins while the stop bit is set
    a_r12_stop_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !s_q.busy) |=> !s_q.busy);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int HALF_DIV   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_re,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_ovf,
    output logic              sck,
    output logic              sout,
    output logic              cs_n,
    input  logic              sin
);
    ctrl_t c_d, c_q;
    logic tx_clr, rx_clr, tx_pop, rx_push;
    logic [DATA_W-1:0] tx_head, rx_word;

    assign tx_clr = cfg_we && cfg_wdata[CB_TX_CLR];
    assign rx_clr = cfg_we && cfg_wdata[CB_RX_CLR];

    always_comb begin
        c_d = c_q;
        if (cfg_we) begin
            c_d.stop     = cfg_wdata[CB_STOP];
            c_d.tx_sgl   = cfg_wdata[CB_TX_SGL];
            c_d.rx_sgl   = cfg_wdata[CB_RX_SGL];
            c_d.dly_code = cfg_wdata[CB_DLY_LO +: 2];
        end
        if (rx_push && rx_full) c_d.ovf = 1'b1;
        if (rx_clr)             c_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.stop <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cfg_rdata = {c_q.dly_code, 2'b00, c_q.rx_sgl, c_q.tx_sgl, c_q.stop};
    assign rx_ovf    = c_q.ovf;

    spi_word_buf #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk, .rst_n,
        .single(c_q.tx_sgl), .flush(tx_clr),
        .push(tx_we), .push_data(tx_wdata), .pop(tx_pop),
        .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_word_buf #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk, .rst_n,
        .single(c_q.rx_sgl), .flush(rx_clr),
        .push(rx_push), .push_data(rx_word), .pop(rx_re),
        .head(rx_rdata), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.W(DATA_W), .HALF_DIV(HALF_DIV)) u_eng (
        .clk, .rst_n,
        .stop(c_q.stop), .dly(decode_delay(c_q.dly_code)),
        .tx_avail(!tx_empty), .tx_word(tx_head), .tx_pop,
        .rx_push, .rx_word, .sin, .sck, .sout, .cs_n
    );

    // R11: the overflow flag holds until an rx flush
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ovf && !rx_clr) |=> c_q.ovf);
    // R2: flush strobes never appear in the readback
    a_r2_flush_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[CB_TX_CLR] == 1'b0 && cfg_rdata[CB_RX_CLR] == 1'b0));
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic [6:0]  cfg_rdata;
    logic        tx_we = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        tx_full, tx_empty;
    logic        rx_re = 1'b0;
    logic [15:0] rx_rdata;
    logic        rx_full, rx_empty, rx_ovf;
    logic        sck, sout, cs_n;
    logic        sin = 1'b0;

    spi_fifo_master #(.DATA_W(16), .FIFO_DEPTH(4), .HALF_DIV(HALF)) u_dut (
        .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata,
        .tx_we, .tx_wdata, .tx_full, .tx_empty,
        .rx_re, .rx_rdata, .rx_full, .rx_empty, .rx_ovf,
        .sck, .sout, .cs_n, .sin
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int frm_cnt = 0;
    logic [15:0] s_arr [0:127];
    logic [15:0] sent  [0:127];
    logic [15:0] cur_s = '0;
    logic [15:0] got_tx = '0;
    int   k = 0;
    int   sl_lat = 1;
    logic sl_pre = 1'b0;
    time  t_prev = 0, t_last = 0;

    // slave model: output changes sl_lat system clocks after each rising sck
    always @(negedge cs_n) if (rst_n) begin
        cur_s  = s_arr[frm_cnt];
        k      = 0;
        got_tx = '0;
        sin    = sl_pre;
    end
    always begin
        @(posedge sck);
        t_prev = t_last;
        t_last = $time;
        k = k + 1;
        repeat (sl_lat) @(negedge clk);
        sin = cur_s[16 - k];
    end
    always @(negedge sck) got_tx = {got_tx[14:0], sout};
    always @(posedge cs_n) if (rst_n) begin
        sent[frm_cnt] = got_tx;
        frm_cnt = frm_cnt + 1;
    end

    function automatic logic [15:0] exp_rx(input logic [15:0] s, input logic p,
                                           input int code, input int lat);
        int d;
        d = (code == 3) ? 2 : code;
        return (d >= lat) ? s : {p, s[15:1]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic h, input logic txb, input logic rxb,
                             input logic txc, input logic rxc, input logic [1:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {d, rxc, txc, rxb, txb, h};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [15:0] w);
        @(negedge clk);
        tx_we = 1'b1;
        tx_wdata = w;
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic pop(output logic [15:0] w);
        @(negedge clk);
        w = rx_rdata;
        rx_re = 1'b1;
        @(negedge clk);
        rx_re = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int t = 0;
        while (frm_cnt < n && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] w, input int code, input int lat, input logic p);
        int f;
        logic [15:0] r;
        sl_lat = lat;
        sl_pre = p;
        cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, code[1:0]);
        f = frm_cnt;
        push(w);
        wait_frames(f + 1);
        chk("R4 sout word", sent[f], w);
        pop(r);
        chk("R5 captured word", r, exp_rx(s_arr[f], p, code, lat));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] w [0:7];
        logic [15:0] r;
        int f0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) s_arr[i] = 16'($urandom);
        for (int i = 0; i < 8; i++) w[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cfg_rdata", cfg_rdata, 7'h01);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 rx_ovf", rx_ovf, 0);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sck", sck, 0);

        // R2 field layout, flush bits read zero
        cfg_write(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10);
        chk("R2 readback", cfg_rdata, 7'h47);
        cfg_write(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
        chk("R2 readback", cfg_rdata, 7'h21);

        // R3 transmit queue depth and order while stopped
        sl_lat = 1;
        sl_pre = 1'b0;
        f0 = frm_cnt;
        for (int i = 0; i < 4; i++) push(w[i]);
        chk("R3 tx_full after 4", tx_full, 1);
        push(w[4]);
        chk("R3 tx_full after dropped write", tx_full, 1);
        chk("R12 no frame while stopped", frm_cnt, f0);
        cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
        wait_frames(f0 + 4);
        repeat (200) @(negedge clk);
        chk("R3 frame count", frm_cnt, f0 + 4);
        for (int i = 0; i < 4; i++) chk("R3 order", sent[f0 + i], w[i]);
        chk("R3 tx_empty", tx_empty, 1);
        chk("R6 rx_full after 4", rx_full, 1);
        chk("R6 no overflow yet", rx_ovf, 0);

        // R11 overflow
        push(w[5]);
        wait_frames(f0 + 5);
        chk("R11 rx_ovf set", rx_ovf, 1);
        repeat (20) @(negedge clk);
        chk("R11 rx_ovf sticky", rx_ovf, 1);

        // R6 read order
        pop(r);
        chk("R6 first word", r, exp_rx(s_arr[f0], 1'b0, 1, 1));
        pop(r);
        chk("R6 second word", r, exp_rx(s_arr[f0 + 1], 1'b0, 1, 1));

        // R10 rx flush
        cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01);
        chk("R10 rx_empty", rx_empty, 1);
        chk("R10 ovf cleared", rx_ovf, 0);

        // R6 read of empty queue ignored
        pop(r);
        chk("R6 still empty", rx_empty, 1);
        f0 = frm_cnt;
        push(w[6]);
        wait_frames(f0 + 1);
        pop(r);
        chk("R6 word after empty read", r, exp_rx(s_arr[f0], 1'b0, 1, 1));
        chk("R6 empty after one read", rx_empty, 1);

        // R9 tx flush vs ordinary write
        cfg_write(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
        for (int i = 0; i < 3; i++) push(w[i]);
        chk("R9 queued", tx_empty, 0);
        cfg_write(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01);
        chk("R9 flushed", tx_empty, 1);
        push(w[7]);
        cfg_write(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
        chk("R9 zero flush bit keeps word", tx_empty, 0);
        f0 = frm_cnt;
        cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
        wait_frames(f0 + 1);
        repeat (200) @(negedge clk);
        chk("R9 one frame", frm_cnt, f0 + 1);
        chk("R9 frame word", sent[f0], w[7]);
        pop(r);

        // R7 transmit single buffer
        cfg_write(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01);
        push(w[1]);
        chk("R7 full after one", tx_full, 1);
        push(w[2]);
        f0 = frm_cnt;
        cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01);
        wait_frames(f0 + 1);
        repeat (200) @(negedge clk);
        chk("R7 one frame", frm_cnt, f0 + 1);
        chk("R7 held word", sent[f0], w[1]);
        pop(r);

        // R8 receive single buffer
        cfg_write(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01);
        f0 = frm_cnt;
        push(w[3]);
        push(w[4]);
        wait_frames(f0 + 1);
        chk("R8 full after one frame", rx_full, 1);
        wait_frames(f0 + 2);
        chk("R8 overflow on second", rx_ovf, 1);
        pop(r);
        chk("R8 kept first word", r, exp_rx(s_arr[f0], 1'b0, 1, 1));
        chk("R8 empty after read", rx_empty, 1);
        cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01);

        // R12 stop mid-frame
        f0 = frm_cnt;
        push(w[5]);
        push(w[6]);
        begin
            int t = 0;
            while (cs_n && t < 1000) begin
                @(negedge clk);
                t++;
            end
        end
        cfg_write(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
        wait_frames(f0 + 1);
        repeat (300) @(negedge clk);
        chk("R12 running frame finished", frm_cnt, f0 + 1);
        chk("R12 word waits", tx_empty, 0);
        chk("R12 cs_n idle", cs_n, 1);
        chk("R12 finished frame word", sent[f0], w[5]);
        pop(r);
        chk("R12 finished frame data", r, exp_rx(s_arr[f0], 1'b0, 1, 1));
        cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
        wait_frames(f0 + 2);
        chk("R12 resumed", sent[f0 + 1], w[6]);
        pop(r);

        // R5 every delay code against both slave latencies
        for (int lat = 1; lat <= 2; lat++)
            for (int code = 0; code < 4; code++)
                run_frame(16'($urandom), code, lat, 1'($urandom));
        chk("R4 sck period", 32'(t_last - t_prev), 32'(2 * HALF * CLK_PERIOD));
        chk("R4 sck low when idle", sck, 0);

        // random frames
        for (int i = 0; i < 16; i++)
            run_frame(16'($urandom), int'($urandom % 4), 1 + int'($urandom % 2), 1'($urandom));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule